// File: doc/BRIEF.md
# UART Register and Interrupt Controller

This block is the software-visible face of a serial port. It decodes a simple single-cycle word bus into eight 32-bit registers: line control, a live status word, a data window onto the two character FIFOs, an interrupt enable mask, an interrupt cause word, FIFO threshold levels, and a pair of command registers. One command register sets bits and the other clears them. The block does not hold the FIFOs or the serial engines. It reads their levels and flags through input ports, and it drives their pop, push and reset strobes, the modem control lines and the line configuration word.

Raw interrupt sources come from two places. Threshold comparisons against the FIFO levels give sources that follow the levels. Edge events, such as a change on the clear-to-send line, a receive timeout, a line error, DMA completions and data-terminal-ready edges, are latched until software clears them. The cause word shows every source twice: gated by the mask in the low half, and raw from bit 16 up. Software clears latched events by writing back the cause word it read. A single interrupt line is the OR of the enabled sources. When flow control is enabled, the ready-to-send output drops on its own once the receive FIFO reaches a programmed level.

Top module: `uart_csr_top`

## Requirements
- R1: After reset, control, mask, trigger and command registers read 0, all modem outputs and both FIFO reset strobes are low, and the interrupt line is low.
- R2: Word index 0 (control) reads back all 32 written bits and drives `ctrlWord`. Index 3 (mask) keeps bits [9:0]. Index 5 (triggers) keeps receive level [4:0], transmit level [11:8] and flow level [20:16]. All other bits read 0.
- R3: Word index 1 (status) reads receive count at [6:0], transmit free space at [12:8], tx active 14, rx active 15, rx overflow 16, tx overflow 17, parity 18, framing 19, break 20, clear-to-send 25 and clock on 31. All other bits are 0.
- R4: A read of index 2 returns `rxData` in [7:0] and pulses `rxPop` in the same cycle only if the receive count is nonzero. A write of index 2 pulses `txPush` only if free space is nonzero. A write with no free space instead sets the sticky tx overflow status bit.
- R5: A write to index 6 sets every command bit written as 1, and a write to index 7 clears them. Bits 0..5 drive ring, carrier detect, data-set-ready, tx break, finish-and-wait and ready-to-send. Indices 6 and 7 both read the command bits.
- R6: Writing bit 6 (bit 7) to index 6 gives a one-cycle `rxFifoClr` (`txFifoClr`) pulse in the following cycle. These bits always read 0. The tx reset pulse clears the tx overflow status.
- R7: Source 1 (rx data available) is high while the receive count is nonzero and at least the rx level. Source 2 (tx data needed) is high while free space is at least the tx level.
- R8: Source 0 latches any change of `ctsIn`, sources 3 and 4 latch `tmoEvt` and `lineEvt`, sources 5..7 latch `dmaEvt[0..2]`, and sources 8 and 9 latch rising and falling edges of `dtrIn`.
- R9: Index 4 reads masked sources at [9:0] and raw sources at [25:16]. A write to index 4 clears each latched source whose bit is 1 in either half. Level sources cannot be cleared.
- R10: `irqOut` is high exactly when some source is both raw-active and enabled in the mask.
- R11: `rtsOut` follows command bit 5, except that it is forced low while control bit 23 is set and the receive count is at or above the flow level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWordAddr | input | 3 | Word index (byte offset / 4) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| rxCount | input | 7 | Receive FIFO occupancy |
| txFree | input | 5 | Transmit FIFO free entries |
| rxData | input | 8 | Receive FIFO head character |
| txActive | input | 1 | Transmitter busy |
| rxActive | input | 1 | Receiver busy |
| rxOvfErr | input | 1 | Receive overflow flag |
| parityErr | input | 1 | Parity error flag |
| framingErr | input | 1 | Framing error flag |
| breakDet | input | 1 | Break detected flag |
| ctsIn | input | 1 | Clear-to-send line |
| dtrIn | input | 1 | Data-terminal-ready line |
| clkOn | input | 1 | Baud clock running |
| tmoEvt | input | 1 | Receive timeout event pulse |
| lineEvt | input | 1 | Line error event pulse |
| dmaEvt | input | 3 | tx done, rx done, rx timeout DMA events |
| rxPop | output | 1 | Pop receive FIFO |
| txPush | output | 1 | Push transmit FIFO |
| txData | output | 8 | Character pushed |
| rxFifoClr | output | 1 | Receive FIFO reset pulse |
| txFifoClr | output | 1 | Transmit FIFO reset pulse |
| ctrlWord | output | 32 | Line configuration |
| riOut | output | 1 | Ring indicator out |
| dcdOut | output | 1 | Carrier detect out |
| dsrOut | output | 1 | Data-set-ready out |
| txBreak | output | 1 | Force break on line |
| txFinishWait | output | 1 | Finish current frame and hold |
| rtsOut | output | 1 | Ready-to-send |
| irqOut | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check that FIFO strobes never pop an empty FIFO or push into a full one, and that the two strobes never coincide. They also check that each FIFO reset pulse comes from a set-command write one cycle earlier, and that a zero mask keeps the interrupt line low. Other behaviours depend on the order of earlier accesses, and only the bench scenarios can show them. These are the latch-then-write-back clearing of edge sources, the rule that threshold sources survive a clear, the sticky tx overflow and its release by the FIFO reset, set/clear command ordering, and the automatic ready-to-send drop near the flow level.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
  localparam int NUM_SRC = 10;
  localparam int RAW_LSB = 16;
  localparam int MODEM_W = 6;
  localparam int RXCLR_BIT = 6;
  localparam int TXCLR_BIT = 7;
  localparam int RXTRIG_W = 5;
  localparam int TXTRIG_W = 4;
  localparam int AFC_W = 5;
  // sources whose raw state follows a level instead of a latch
  localparam logic [NUM_SRC-1:0] LEVEL_SRC = 10'b00_0000_0110;

  typedef enum logic [2:0] {
    RG_CTRL = 3'd0, RG_STAT = 3'd1, RG_DATA = 3'd2, RG_MASK = 3'd3,
    RG_CAUSE = 3'd4, RG_TRIG = 3'd5, RG_CSET = 3'd6, RG_CCLR = 3'd7
  } regIdx_e;

  typedef struct packed {
    logic    wrCtrl;
    logic    wrMask;
    logic    wrCause;
    logic    wrTrig;
    logic    wrSet;
    logic    wrClr;
    logic    wrDataFull;
    regIdx_e rdIdx;
  } csrStrobe_t;
endpackage

// File: rtl/uart_csr_ctrl.sv
module uart_csr_ctrl
  import uart_csr_pkg::*;
#(
  parameter int RXCNT_W = 7,
  parameter int TXFREE_W = 5
) (
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [2:0]          busWordAddr,
  input  logic [RXCNT_W-1:0]  rxCount,
  input  logic [TXFREE_W-1:0] txFree,
  output csrStrobe_t          stb,
  output logic                rxPop,
  output logic                txPush
);
  regIdx_e idx;
  logic    wrAcc, rdAcc, rxEmpty, txFull;

  assign idx     = regIdx_e'(busWordAddr);
  assign wrAcc   = busSel & busWrite;
  assign rdAcc   = busSel & ~busWrite;
  assign rxEmpty = (rxCount == '0);
  assign txFull  = (txFree == '0);

  always_comb begin
    stb            = '0;
    stb.rdIdx      = idx;
    stb.wrCtrl     = wrAcc && (idx == RG_CTRL);
    stb.wrMask     = wrAcc && (idx == RG_MASK);
    stb.wrCause    = wrAcc && (idx == RG_CAUSE);
    stb.wrTrig     = wrAcc && (idx == RG_TRIG);
    stb.wrSet      = wrAcc && (idx == RG_CSET);
    stb.wrClr      = wrAcc && (idx == RG_CCLR);
    stb.wrDataFull = wrAcc && (idx == RG_DATA) && txFull;
  end

  assign rxPop  = rdAcc && (idx == RG_DATA) && !rxEmpty;
  assign txPush = wrAcc && (idx == RG_DATA) && !txFull;
endmodule

// File: rtl/uart_csr_dpath.sv
module uart_csr_dpath
  import uart_csr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RXCNT_W = 7,
  parameter int TXFREE_W = 5,
  parameter int CHAR_W = 8,
  parameter int DMA_N = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  csrStrobe_t          stb,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [RXCNT_W-1:0]  rxCount,
  input  logic [TXFREE_W-1:0] txFree,
  input  logic [CHAR_W-1:0]   rxData,
  input  logic                txActive,
  input  logic                rxActive,
  input  logic                rxOvfErr,
  input  logic                parityErr,
  input  logic                framingErr,
  input  logic                breakDet,
  input  logic                ctsIn,
  input  logic                dtrIn,
  input  logic                clkOn,
  input  logic                tmoEvt,
  input  logic                lineEvt,
  input  logic [DMA_N-1:0]    dmaEvt,
  output logic [DATA_W-1:0]   busRdata,
  output logic [DATA_W-1:0]   ctrlWord,
  output logic [MODEM_W-1:0]  modemOut,
  output logic                rxFifoClr,
  output logic                txFifoClr,
  output logic                rtsOut,
  output logic [NUM_SRC-1:0]  causeRaw,
  output logic [NUM_SRC-1:0]  maskCur
);
  localparam int TXFREE_LSB = 8;
  localparam int FLOW_BIT   = 23;
  localparam int RTS_BIT    = 5;

  logic [DATA_W-1:0]   ctrlReg;
  logic [NUM_SRC-1:0]  maskReg;
  logic [RXTRIG_W-1:0] rxTrig;
  logic [TXTRIG_W-1:0] txTrig;
  logic [AFC_W-1:0]    afcLvl;
  logic [MODEM_W-1:0]  cmdReg;
  logic rxClrQ, txClrQ, txOvfQ, ctsQ, dtrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      maskReg <= '0;
      rxTrig  <= '0;
      txTrig  <= '0;
      afcLvl  <= '0;
      cmdReg  <= '0;
      rxClrQ  <= 1'b0;
      txClrQ  <= 1'b0;
      txOvfQ  <= 1'b0;
      ctsQ    <= 1'b0;
      dtrQ    <= 1'b0;
    end else begin
      if (stb.wrCtrl) ctrlReg <= busWdata;
      if (stb.wrMask) maskReg <= busWdata[NUM_SRC-1:0];
      if (stb.wrTrig) begin
        rxTrig <= busWdata[RXTRIG_W-1:0];
        txTrig <= busWdata[8 +: TXTRIG_W];
        afcLvl <= busWdata[16 +: AFC_W];
      end
      if (stb.wrSet)      cmdReg <= cmdReg | busWdata[MODEM_W-1:0];
      else if (stb.wrClr) cmdReg <= cmdReg & ~busWdata[MODEM_W-1:0];
      rxClrQ <= stb.wrSet & busWdata[RXCLR_BIT];
      txClrQ <= stb.wrSet & busWdata[TXCLR_BIT];
      txOvfQ <= (txOvfQ & ~txClrQ) | stb.wrDataFull;
      ctsQ   <= ctsIn;
      dtrQ   <= dtrIn;
    end
  end

  // threshold sources
  logic rxAvail, txNeed;
  assign rxAvail = (rxCount != '0) && (rxCount >= RXCNT_W'(rxTrig));
  assign txNeed  = (txFree >= TXFREE_W'(txTrig));

  logic [NUM_SRC-1:0] evtVec;
  assign evtVec = {dtrQ & ~dtrIn, ~dtrQ & dtrIn, dmaEvt, lineEvt, tmoEvt,
                   txNeed, rxAvail, ctsIn ^ ctsQ};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (LEVEL_SRC[s]) begin : g_level
      assign causeRaw[s] = evtVec[s];
    end else begin : g_latch
      logic held;
      logic clrHit;
      assign clrHit = stb.wrCause & (busWdata[s] | busWdata[RAW_LSB + s]);
      always_ff @(posedge clk) begin
        if (!rstN) held <= 1'b0;
        else       held <= (held & ~clrHit) | evtVec[s];
      end
      assign causeRaw[s] = held;
    end
  end

  // read mux
  logic [DATA_W-1:0] statWord, causeWord;
  always_comb begin
    statWord = '0;
    statWord[RXCNT_W-1:0] = rxCount;
    statWord[TXFREE_LSB +: TXFREE_W] = txFree;
    statWord[14] = txActive;
    statWord[15] = rxActive;
    statWord[16] = rxOvfErr;
    statWord[17] = txOvfQ;
    statWord[18] = parityErr;
    statWord[19] = framingErr;
    statWord[20] = breakDet;
    statWord[25] = ctsIn;
    statWord[31] = clkOn;
    causeWord = '0;
    causeWord[NUM_SRC-1:0] = causeRaw & maskReg;
    causeWord[RAW_LSB +: NUM_SRC] = causeRaw;
  end

  always_comb begin
    busRdata = '0;
    unique case (stb.rdIdx)
      RG_CTRL:  busRdata = ctrlReg;
      RG_STAT:  busRdata = statWord;
      RG_DATA:  busRdata[CHAR_W-1:0] = rxData;
      RG_MASK:  busRdata[NUM_SRC-1:0] = maskReg;
      RG_CAUSE: busRdata = causeWord;
      RG_TRIG: begin
        busRdata[RXTRIG_W-1:0] = rxTrig;
        busRdata[8 +: TXTRIG_W] = txTrig;
        busRdata[16 +: AFC_W] = afcLvl;
      end
      RG_CSET, RG_CCLR: busRdata[MODEM_W-1:0] = cmdReg;
      default: busRdata = '0;
    endcase
  end

  assign ctrlWord  = ctrlReg;
  assign modemOut  = cmdReg;
  assign rxFifoClr = rxClrQ;
  assign txFifoClr = txClrQ;
  assign maskCur   = maskReg;
  assign rtsOut    = cmdReg[RTS_BIT] &
                     ~(ctrlReg[FLOW_BIT] & (rxCount >= RXCNT_W'(afcLvl)));
endmodule

// File: rtl/uart_csr_top.sv
module uart_csr_top
  import uart_csr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RXCNT_W = 7,
  parameter int TXFREE_W = 5,
  parameter int CHAR_W = 8,
  parameter int DMA_N = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [2:0]          busWordAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [RXCNT_W-1:0]  rxCount,
  input  logic [TXFREE_W-1:0] txFree,
  input  logic [CHAR_W-1:0]   rxData,
  input  logic                txActive,
  input  logic                rxActive,
  input  logic                rxOvfErr,
  input  logic                parityErr,
  input  logic                framingErr,
  input  logic                breakDet,
  input  logic                ctsIn,
  input  logic                dtrIn,
  input  logic                clkOn,
  input  logic                tmoEvt,
  input  logic                lineEvt,
  input  logic [DMA_N-1:0]    dmaEvt,
  output logic                rxPop,
  output logic                txPush,
  output logic [CHAR_W-1:0]   txData,
  output logic                rxFifoClr,
  output logic                txFifoClr,
  output logic [DATA_W-1:0]   ctrlWord,
  output logic                riOut,
  output logic                dcdOut,
  output logic                dsrOut,
  output logic                txBreak,
  output logic                txFinishWait,
  output logic                rtsOut,
  output logic                irqOut
);
  csrStrobe_t         stb;
  logic [MODEM_W-1:0] modemOut;
  logic [NUM_SRC-1:0] causeRaw, maskCur;

  uart_csr_ctrl #(.RXCNT_W(RXCNT_W), .TXFREE_W(TXFREE_W)) ctrl_i (
    .busSel(busSel), .busWrite(busWrite), .busWordAddr(busWordAddr),
    .rxCount(rxCount), .txFree(txFree), .stb(stb),
    .rxPop(rxPop), .txPush(txPush)
  );

  uart_csr_dpath #(.DATA_W(DATA_W), .RXCNT_W(RXCNT_W), .TXFREE_W(TXFREE_W),
                   .CHAR_W(CHAR_W), .DMA_N(DMA_N)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .rxCount(rxCount), .txFree(txFree), .rxData(rxData),
    .txActive(txActive), .rxActive(rxActive), .rxOvfErr(rxOvfErr),
    .parityErr(parityErr), .framingErr(framingErr), .breakDet(breakDet),
    .ctsIn(ctsIn), .dtrIn(dtrIn), .clkOn(clkOn), .tmoEvt(tmoEvt),
    .lineEvt(lineEvt), .dmaEvt(dmaEvt), .busRdata(busRdata),
    .ctrlWord(ctrlWord), .modemOut(modemOut), .rxFifoClr(rxFifoClr),
    .txFifoClr(txFifoClr), .rtsOut(rtsOut), .causeRaw(causeRaw),
    .maskCur(maskCur)
  );

  assign txData       = busWdata[CHAR_W-1:0];
  assign riOut        = modemOut[0];
  assign dcdOut       = modemOut[1];
  assign dsrOut       = modemOut[2];
  assign txBreak      = modemOut[3];
  assign txFinishWait = modemOut[4];
  assign irqOut       = |(causeRaw & maskCur);
endmodule

// File: rtl/uart_csr_chk.sv
module uart_csr_chk #(
  parameter int DATA_W = 32,
  parameter int RXCNT_W = 7,
  parameter int TXFREE_W = 5,
  parameter int NSRC = 10
) (
  input logic                clk,
  input logic                rstN,
  input logic                busSel,
  input logic                busWrite,
  input logic [2:0]          busWordAddr,
  input logic [DATA_W-1:0]   busWdata,
  input logic [RXCNT_W-1:0]  rxCount,
  input logic [TXFREE_W-1:0] txFree,
  input logic                rxPop,
  input logic                txPush,
  input logic                rxFifoClr,
  input logic                txFifoClr,
  input logic                irqOut,
  input logic [NSRC-1:0]     maskCur
);
  logic setWr;
  assign setWr = busSel && busWrite && (busWordAddr == 3'd6);

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> (rxCount != '0)); // R4
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    txPush |-> (txFree != '0)); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxPop, txPush})); // R4
  AST_RXCLR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFifoClr) |-> $past(setWr && busWdata[6])); // R6
  AST_TXCLR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txFifoClr) |-> $past(setWr && busWdata[7])); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (maskCur == '0) |-> !irqOut); // R10
endmodule

bind uart_csr_top uart_csr_chk #(.DATA_W(DATA_W), .RXCNT_W(RXCNT_W),
                                 .TXFREE_W(TXFREE_W), .NSRC(10)) chk_i (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busWordAddr(busWordAddr), .busWdata(busWdata), .rxCount(rxCount),
  .txFree(txFree), .rxPop(rxPop), .txPush(txPush), .rxFifoClr(rxFifoClr),
  .txFifoClr(txFifoClr), .irqOut(irqOut), .maskCur(maskCur)
);

// File: tb/uart_csr_top_tb.sv
`timescale 1ns/1ps
module uart_csr_top_tb_top;
  logic clk = 0, rstN = 0;
  logic busSel = 0, busWrite = 0;
  logic [2:0] busWordAddr = 0;
  logic [31:0] busWdata = 0, busRdata;
  logic [6:0] rxCount = 0;
  logic [4:0] txFree = 16;
  logic [7:0] rxData = 0;
  logic txActive = 0, rxActive = 0, rxOvfErr = 0, parityErr = 0;
  logic framingErr = 0, breakDet = 0, ctsIn = 0, dtrIn = 0, clkOn = 0;
  logic tmoEvt = 0, lineEvt = 0;
  logic [2:0] dmaEvt = 0;
  logic rxPop, txPush, rxFifoClr, txFifoClr, riOut, dcdOut, dsrOut;
  logic txBreak, txFinishWait, rtsOut, irqOut;
  logic [7:0] txData;
  logic [31:0] ctrlWord;

  always #2.5 clk = ~clk;

  uart_csr_top dut_i (.*);

  int nChk = 0, nBad = 0;
  bit finished = 0;

  // behavioural reference state
  logic [31:0] mCtrl, mMask, mTrig;
  logic [5:0]  mCmd;
  logic [9:0]  mHeld;
  logic mRxClr, mTxClr, mTxOvf, mCts, mDtr;

  always @(posedge clk) begin
    logic [9:0] ev, clr;
    if (!rstN) begin
      mCtrl = 0; mMask = 0; mTrig = 0; mCmd = 0; mHeld = 0;
      mRxClr = 0; mTxClr = 0; mTxOvf = 0; mCts = 0; mDtr = 0;
    end else begin
      ev = 0;
      ev[0] = ctsIn != mCts;
      ev[3] = tmoEvt; ev[4] = lineEvt;
      ev[5] = dmaEvt[0]; ev[6] = dmaEvt[1]; ev[7] = dmaEvt[2];
      ev[8] = dtrIn && !mDtr; ev[9] = !dtrIn && mDtr;
      clr = 0;
      if (mTxClr) mTxOvf = 0;
      mRxClr = 0; mTxClr = 0;
      if (busSel && busWrite) begin
        case (busWordAddr)
          0: mCtrl = busWdata;
          2: if (txFree == 0) mTxOvf = 1;
          3: mMask = busWdata & 32'h3FF;
          4: clr = busWdata[9:0] | busWdata[25:16];
          5: mTrig = busWdata & 32'h001F_0F1F;
          6: begin mCmd = mCmd | busWdata[5:0];
                   mRxClr = busWdata[6]; mTxClr = busWdata[7]; end
          7: mCmd = mCmd & ~busWdata[5:0];
          default: ;
        endcase
      end
      mHeld = ((mHeld & ~clr) | ev) & 10'h3F9;
      mCts = ctsIn; mDtr = dtrIn;
    end
  end

  function automatic logic [9:0] expRaw();
    logic [9:0] r = mHeld;
    r[1] = (rxCount != 0) && (int'(rxCount) >= int'(mTrig[4:0]));
    r[2] = int'(txFree) >= int'(mTrig[11:8]);
    return r;
  endfunction

  function automatic logic [31:0] expRead(input logic [2:0] a);
    logic [31:0] v = 0;
    case (a)
      0: v = mCtrl;
      1: begin v[6:0] = rxCount; v[12:8] = txFree; v[14] = txActive;
         v[15] = rxActive; v[16] = rxOvfErr; v[17] = mTxOvf; v[18] = parityErr;
         v[19] = framingErr; v[20] = breakDet; v[25] = ctsIn; v[31] = clkOn; end
      2: v[7:0] = rxData;
      3: v = mMask;
      4: begin v[9:0] = expRaw() & mMask[9:0]; v[25:16] = expRaw(); end
      5: v = mTrig;
      default: v[5:0] = mCmd;
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compared on every clock, away from the edge
  always @(negedge clk) if (rstN && !finished) begin
    check("R10 irqOut", irqOut, |(expRaw() & mMask[9:0]));
    check("R11 rtsOut", rtsOut, mCmd[5] && !(mCtrl[23] && int'(rxCount) >= int'(mTrig[20:16])));
    check("R5 modem", {txFinishWait, txBreak, dsrOut, dcdOut, riOut}, mCmd[4:0]);
    check("R6 fifoClr", {txFifoClr, rxFifoClr}, {mTxClr, mRxClr});
    check("R2 ctrlWord", ctrlWord, mCtrl);
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busWordAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    @(negedge clk);
    busSel = 1; busWrite = 0; busWordAddr = a;
    #1 check(tag, busRdata, expRead(a));
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: tmoEvt = 1; 1: lineEvt = 1; default: dmaEvt = 3'b111;
    endcase
    @(negedge clk);
    tmoEvt = 0; lineEvt = 0; dmaEvt = 0;
  endtask

  initial begin
    #(5.0 * 20000);
    nBad++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [31:0] causeVal;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    @(negedge clk);
    check("R1 irq", irqOut, 0); check("R1 rts", rtsOut, 0);
    rd(0, "R1 ctrl"); rd(3, "R1 mask"); rd(5, "R1 trig"); rd(6, "R1 cmd");
    // R2 field masking
    wr(0, 32'h0180_0001); rd(0, "R2 ctrl");
    wr(3, 32'hFFFF_FFFF); rd(3, "R2 mask");
    wr(5, 32'hFFFF_FFFF); rd(5, "R2 trig");
    wr(3, 0);
    wr(5, 32'h000A_0804);
    // R3 status layout
    rxCount = 5; txFree = 3; txActive = 1; rxOvfErr = 1; framingErr = 1;
    ctsIn = 1; clkOn = 1;
    rd(1, "R3 status");
    rxActive = 1; parityErr = 1; breakDet = 1; txActive = 0; ctsIn = 0;
    rd(1, "R3 status b");
    // R4 data window
    rxData = 8'hA5;
    @(negedge clk); busSel = 1; busWrite = 0; busWordAddr = 2;
    #1 check("R4 rdata", busRdata, 32'hA5); check("R4 pop", rxPop, 1);
    @(negedge clk); busSel = 0; rxCount = 0;
    @(negedge clk); busSel = 1; busWordAddr = 2;
    #1 check("R4 no pop empty", rxPop, 0);
    @(negedge clk); busSel = 0;
    @(negedge clk); busSel = 1; busWrite = 1; busWordAddr = 2; busWdata = 32'h3C;
    #1 check("R4 push", {txPush, txData}, {1'b1, 8'h3C});
    @(negedge clk); busSel = 0; busWrite = 0; txFree = 0;
    rd(1, "R4 no ovf yet");
    @(negedge clk); busSel = 1; busWrite = 1; busWordAddr = 2;
    #1 check("R4 no push full", txPush, 0);
    @(negedge clk); busSel = 0; busWrite = 0;
    rd(1, "R4 tx overflow sticky");
    // R6 reset pulses
    wr(6, 32'h80); rd(1, "R6 ovf cleared by tx reset");
    wr(6, 32'h40); rd(6, "R6 reset bits read 0");
    // R5 command set/clear
    wr(6, 32'h3F); rd(6, "R5 set");
    wr(7, 32'h05); rd(7, "R5 clear");
    wr(7, 32'h3A); rd(6, "R5 all clear");
    // R7 thresholds
    txFree = 7; rxCount = 3;
    wr(3, 32'h006); rd(4, "R7 below");
    rxCount = 4; rd(4, "R7 rx at level");
    txFree = 8; rd(4, "R7 tx at level");
    // R8 edge events
    wr(3, 32'h3FF);
    ctsIn = 1; pulse(0); pulse(1); pulse(2);
    dtrIn = 1; @(negedge clk); dtrIn = 0;
    rd(4, "R8 all latched");
    ctsIn = 0; @(negedge clk);
    // R9 write-back clear
    @(negedge clk); busSel = 1; busWrite = 0; busWordAddr = 4;
    #1 causeVal = busRdata;
    @(negedge clk); busSel = 0;
    wr(4, causeVal); rd(4, "R9 latched cleared, levels stay");
    pulse(0); wr(4, 32'h0000_0008); rd(4, "R9 low half clears");
    // R10 masking
    wr(3, 0); pulse(1); @(negedge clk); check("R10 masked off", irqOut, 0);
    wr(3, 32'h010); @(negedge clk); check("R10 enabled", irqOut, 1);
    wr(4, 32'h0010_0000); @(negedge clk); check("R10 after clear", irqOut, 0);
    // R11 flow control
    wr(6, 32'h20); rxCount = 9; @(negedge clk); check("R11 below level", rtsOut, 1);
    rxCount = 10; @(negedge clk); check("R11 at level", rtsOut, 0);
    wr(0, 32'h0000_0001); @(negedge clk); check("R11 flow off", rtsOut, 1);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule